// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block decides, every clock cycle, which hardware process of a barrel-style multithreaded core sends its next instruction into the execution pipeline. It keeps a table of process status entries. Each entry holds a program counter, a privilege class (user or supervisor) and a task id. A process that has an instruction in flight cannot be chosen again. It becomes eligible once its retirement comes back. A single process can therefore use at most one pipeline slot, and the whole pipeline fills only when enough processes are ready.

Software-side logic creates processes through a create port. A create request either opens a new task in its class or joins a task that already exists. A kill port removes a process. The execution pipeline reports each finished instruction on the retire port. That report carries the next program counter or a halt indication. The issue port presents the chosen process id, its program counter, its class and its task id, or a bubble when nothing is eligible.

Top module: `barrel_sched`

## Requirements
- R1: While reset is held and afterwards until a create is accepted, `iss_valid`, `cr_ack`, `cr_nak` and `full` are low.
- R2: An accepted create raises `cr_ack` for one cycle on the following cycle, with `cr_pid` equal to the lowest-numbered free slot. The first issue of that process carries the create PC, `iss_super` equal to the requested class and `iss_task` equal to the assigned task id. `cr_ack` and `cr_nak` are never high together.
- R3: Selection is round-robin: the issued id is the first ready id found by searching upward from the previously issued id plus one, wrapping from slot 49 to slot 0. As a result, with every slot ready, ids come out in strictly increasing order modulo 50.
- R4: A process is never issued while it has an instruction in flight. If its retire is sampled at clock edge E, the earliest issue that can show it is the one registered at edge E+1.
- R5: A retire with `ret_halt` low makes the next issue of that process carry `ret_pc`.
- R6: A retire with `ret_halt` high frees the slot. The process is not issued again, and the slot becomes available to later creates.
- R7: In a cycle with no ready process, the next registered issue has `iss_valid` low.
- R8: Task handling depends on `cr_new_task`. With `cr_new_task`=1, the create receives the lowest task id in 0..6 that is unused in its class, reported on `cr_task_id`. With `cr_new_task`=0, it joins task `cr_task` and is accepted only if that task of that class holds at least one live process. A task id becomes free again once its last process is freed.
- R9: `cr_super`=1 selects the supervisor class and 0 the user class. A new-task create is refused with `cr_nak` when all seven ids of its class are in use. The other class is not affected.
- R10: `full` is high exactly when all 50 slots are occupied. A create request while `full` is high is answered with `cr_nak`.
- R11: A kill of a ready process removes it at once, and it is not issued at the edge where the kill is sampled. A kill of a process with an instruction in flight lets that instruction finish, then frees the slot at its retire instead of making the process ready again.
- R12: When retires return seven cycles after issue (an eight-stage pipeline), a lone process issues exactly once every eight cycles. Eight or more live processes give an issue on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_valid | input | 1 | Create request |
| cr_pc | input | 16 | Start PC of the new process |
| cr_super | input | 1 | Class of the new process: 1 supervisor, 0 user |
| cr_new_task | input | 1 | 1: open a new task, 0: join `cr_task` |
| cr_task | input | 3 | Task id to join when `cr_new_task` is 0 |
| cr_ack | output | 1 | Create accepted (one-cycle pulse) |
| cr_nak | output | 1 | Create refused (one-cycle pulse) |
| cr_pid | output | 6 | Slot given to the accepted process |
| cr_task_id | output | 3 | Task id of the accepted process |
| kill_valid | input | 1 | Kill request |
| kill_pid | input | 6 | Slot to kill |
| ret_valid | input | 1 | Instruction retired |
| ret_pid | input | 6 | Process of the retired instruction |
| ret_pc | input | 16 | Next PC of that process |
| ret_halt | input | 1 | Process ends instead of continuing |
| iss_valid | output | 1 | Issue slot holds an instruction (low: bubble) |
| iss_pid | output | 6 | Issued process id |
| iss_pc | output | 16 | PC to fetch |
| iss_super | output | 1 | Class of the issued process |
| iss_task | output | 3 | Task id of the issued process |
| full | output | 1 | All slots occupied |

## Verification
The bench runs a model of the eight-stage pipeline that returns every issue as a retire seven cycles later. Against that model it checks two rates: a lone process issues on every eighth cycle, and a full table rotates in strict id order. A design that picked by fixed priority would starve high ids, and one that re-armed a process too early would issue it twice within one pipeline pass. Kills are timed to land on a process at the very edge it becomes ready and also on a process in flight; a design that ignored the kill at the pick, or re-enqueued a killed process on retire, would keep issuing it. The task pool is pushed to seven tasks in one class and then asked for an eighth, and joins to absent tasks are attempted; a leaky counter would refuse good requests or accept bad ones. A fill to all fifty slots checks the full flag and the refusal that follows it.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_READY = 2'd1,
    SLOT_BUSY  = 2'd2
  } slot_st_t;
endpackage

// File: rtl/bps_rr_pick.sv
module bps_rr_pick #(
  parameter int N  = 50,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // search upward from last+1, wrapping once around the table
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int s = 1; s <= N; s++) begin
      int k;
      k = int'(last) + s;
      if (k >= N) k = k - N;
      if (k >= N) k = k - N;
      if (!hit && req[k]) begin
        hit = 1'b1;
        idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/bps_low_free.sv
module bps_low_free #(
  parameter int N  = 50,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  free_vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (free_vec[k]) begin
        hit = 1'b1;
        idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/bps_task_pool.sv
module bps_task_pool #(
  parameter int TASKS = 7,
  parameter int CW    = 6,
  parameter int TW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_en,
  input  logic          inc_sup,
  input  logic [TW-1:0] inc_tid,
  input  logic          da_en,
  input  logic          da_sup,
  input  logic [TW-1:0] da_tid,
  input  logic          db_en,
  input  logic          db_sup,
  input  logic [TW-1:0] db_tid,
  input  logic          q_sup,
  input  logic [TW-1:0] q_tid,
  output logic          q_free_ok,
  output logic [TW-1:0] q_free_tid,
  output logic          q_live
);
  localparam int NC = 2 * TASKS;

  logic [NC-1:0] idle_vec;

  for (genvar c = 0; c < NC; c++) begin : g_cnt
    localparam int CLS = c / TASKS;
    localparam int TID = c % TASKS;
    logic [CW-1:0] cnt;
    logic up, dn_a, dn_b;

    assign up   = inc_en && (inc_sup == (CLS == 1)) && (int'(inc_tid) == TID);
    assign dn_a = da_en  && (da_sup  == (CLS == 1)) && (int'(da_tid)  == TID);
    assign dn_b = db_en  && (db_sup  == (CLS == 1)) && (int'(db_tid)  == TID);

    always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt + CW'(up) - CW'(dn_a) - CW'(dn_b);
    end

    assign idle_vec[c] = (cnt == '0);

    // a task never loses more processes than it holds
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
      (dn_a || dn_b) |-> (cnt >= (CW'(dn_a) + CW'(dn_b))));
  end

  always_comb begin
    int base;
    base       = q_sup ? TASKS : 0;
    q_free_ok  = 1'b0;
    q_free_tid = '0;
    for (int t = TASKS - 1; t >= 0; t--) begin
      if (idle_vec[base + t]) begin
        q_free_ok  = 1'b1;
        q_free_tid = TW'(t);
      end
    end
    q_live = 1'b0;
    if (int'(q_tid) < TASKS) q_live = !idle_vec[base + int'(q_tid)];
  end
endmodule

// File: rtl/barrel_sched.sv
module barrel_sched
  import barrel_pkg::*;
#(
  parameter int N_SLOTS = 50,
  parameter int PC_W    = 16,
  parameter int TASKS   = 7,
  localparam int PID_W  = $clog2(N_SLOTS),
  localparam int TASK_W = (TASKS > 1) ? $clog2(TASKS) : 1,
  localparam int OCC_W  = $clog2(N_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cr_valid,
  input  logic [PC_W-1:0]   cr_pc,
  input  logic              cr_super,
  input  logic              cr_new_task,
  input  logic [TASK_W-1:0] cr_task,
  output logic              cr_ack,
  output logic              cr_nak,
  output logic [PID_W-1:0]  cr_pid,
  output logic [TASK_W-1:0] cr_task_id,
  input  logic              kill_valid,
  input  logic [PID_W-1:0]  kill_pid,
  input  logic              ret_valid,
  input  logic [PID_W-1:0]  ret_pid,
  input  logic [PC_W-1:0]   ret_pc,
  input  logic              ret_halt,
  output logic              iss_valid,
  output logic [PID_W-1:0]  iss_pid,
  output logic [PC_W-1:0]   iss_pc,
  output logic              iss_super,
  output logic [TASK_W-1:0] iss_task,
  output logic              full
);
  // per-slot control state and status-word payload
  slot_st_t          st     [N_SLOTS];
  logic              dying  [N_SLOTS];
  logic [PC_W-1:0]   pc_q   [N_SLOTS];
  logic              sup_q  [N_SLOTS];
  logic [TASK_W-1:0] tsk_q  [N_SLOTS];

  logic [OCC_W-1:0]  occ_q;
  logic [PID_W-1:0]  last_q;
  logic [N_SLOTS-1:0] free_vec, ready_vec;

  logic kill_in, kill_free_now, kill_mark;
  logic ret_in, ret_free;
  logic lf_ok, pk_ok;
  logic [PID_W-1:0] lf_idx, pk_idx;
  logic tp_free_ok, tp_live, accept;
  logic [TASK_W-1:0] tp_free_tid, task_sel;

  assign kill_in       = kill_valid && (int'(kill_pid) < N_SLOTS);
  assign kill_free_now = kill_in && (st[kill_pid] == SLOT_READY);
  assign kill_mark     = kill_in && (st[kill_pid] == SLOT_BUSY);
  assign ret_in        = ret_valid && (int'(ret_pid) < N_SLOTS) && (st[ret_pid] == SLOT_BUSY);
  assign ret_free      = ret_in && (ret_halt || dying[ret_pid] || (kill_mark && kill_pid == ret_pid));

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_vec
    assign free_vec[i]  = (st[i] == SLOT_FREE);
    assign ready_vec[i] = (st[i] == SLOT_READY) && !(kill_in && int'(kill_pid) == i);
  end

  bps_low_free #(.N(N_SLOTS), .IW(PID_W)) u_free (
    .free_vec(free_vec), .hit(lf_ok), .idx(lf_idx)
  );

  bps_rr_pick #(.N(N_SLOTS), .IW(PID_W)) u_pick (
    .req(ready_vec), .last(last_q), .hit(pk_ok), .idx(pk_idx)
  );

  bps_task_pool #(.TASKS(TASKS), .CW(OCC_W), .TW(TASK_W)) u_tasks (
    .clk(clk), .rst(rst),
    .inc_en(accept), .inc_sup(cr_super), .inc_tid(task_sel),
    .da_en(ret_free), .da_sup(sup_q[ret_pid]), .da_tid(tsk_q[ret_pid]),
    .db_en(kill_free_now), .db_sup(sup_q[kill_pid]), .db_tid(tsk_q[kill_pid]),
    .q_sup(cr_super), .q_tid(cr_task),
    .q_free_ok(tp_free_ok), .q_free_tid(tp_free_tid), .q_live(tp_live)
  );

  assign full     = (occ_q == OCC_W'(N_SLOTS));
  assign task_sel = cr_new_task ? tp_free_tid : cr_task;
  assign accept   = cr_valid && !full && lf_ok && (cr_new_task ? tp_free_ok : tp_live);

  // slot state machine: create, issue, retire and kill never hit the same
  // slot except retire+kill, which the retire branch resolves
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_SLOTS; i++) begin
      if (rst) begin
        st[i]    <= SLOT_FREE;
        dying[i] <= 1'b0;
      end else if (accept && int'(lf_idx) == i) begin
        st[i]    <= SLOT_READY;
        dying[i] <= 1'b0;
      end else if (pk_ok && int'(pk_idx) == i) begin
        st[i]    <= SLOT_BUSY;
      end else if (ret_in && int'(ret_pid) == i) begin
        st[i]    <= ret_free ? SLOT_FREE : SLOT_READY;
        dying[i] <= 1'b0;
      end else if (kill_in && int'(kill_pid) == i) begin
        if (st[i] == SLOT_READY) st[i] <= SLOT_FREE;
        if (st[i] == SLOT_BUSY)  dying[i] <= 1'b1;
      end
    end
  end

  // payload table: no reset, written only on create and live retire
  always_ff @(posedge clk) begin
    if (accept) begin
      pc_q[lf_idx]  <= cr_pc;
      sup_q[lf_idx] <= cr_super;
      tsk_q[lf_idx] <= task_sel;
    end
    if (ret_in && !ret_free) pc_q[ret_pid] <= ret_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q      <= '0;
      last_q     <= PID_W'(N_SLOTS - 1);
      iss_valid  <= 1'b0;
      iss_pid    <= '0;
      iss_pc     <= '0;
      iss_super  <= 1'b0;
      iss_task   <= '0;
      cr_ack     <= 1'b0;
      cr_nak     <= 1'b0;
      cr_pid     <= '0;
      cr_task_id <= '0;
    end else begin
      occ_q      <= occ_q + OCC_W'(accept) - OCC_W'(ret_free) - OCC_W'(kill_free_now);
      iss_valid  <= pk_ok;
      if (pk_ok) begin
        last_q    <= pk_idx;
        iss_pid   <= pk_idx;
        iss_pc    <= pc_q[pk_idx];
        iss_super <= sup_q[pk_idx];
        iss_task  <= tsk_q[pk_idx];
      end
      cr_ack     <= accept;
      cr_nak     <= cr_valid && !accept;
      cr_pid     <= lf_idx;
      cr_task_id <= task_sel;
    end
  end

  assert_ack_nak_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(cr_ack && cr_nak));

  assert_single_inflight_R4: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (st[iss_pid] != SLOT_READY));

  assert_halt_frees_R6: assert property (@(posedge clk) disable iff (rst)
    (ret_in && ret_halt) |=> (st[$past(ret_pid)] == SLOT_FREE));

  assert_bubble_R7: assert property (@(posedge clk) disable iff (rst)
    (ready_vec == '0) |=> !iss_valid);

  assert_full_matches_R10: assert property (@(posedge clk) disable iff (rst)
    full == (free_vec == '0));

  assert_refuse_full_R10: assert property (@(posedge clk) disable iff (rst)
    (cr_valid && full) |=> cr_nak);

  assert_kill_ready_R11: assert property (@(posedge clk) disable iff (rst)
    kill_free_now |=> (st[$past(kill_pid)] == SLOT_FREE));
endmodule

// File: tb/barrel_sched_test.sv
module barrel_sched_test;
  localparam int N   = 50;
  localparam int PCW = 16;
  localparam int TW  = 3;
  localparam int PW  = 6;
  localparam int DEP = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic cr_valid, cr_super, cr_new_task;
  logic [PCW-1:0] cr_pc;
  logic [TW-1:0] cr_task, cr_task_id, iss_task;
  logic cr_ack, cr_nak, full;
  logic [PW-1:0] cr_pid, kill_pid, ret_pid, iss_pid;
  logic kill_valid, ret_valid, ret_halt, iss_valid, iss_super;
  logic [PCW-1:0] ret_pc, iss_pc;

  barrel_sched uut (
    .clk(clk), .rst(rst),
    .cr_valid(cr_valid), .cr_pc(cr_pc), .cr_super(cr_super),
    .cr_new_task(cr_new_task), .cr_task(cr_task),
    .cr_ack(cr_ack), .cr_nak(cr_nak), .cr_pid(cr_pid), .cr_task_id(cr_task_id),
    .kill_valid(kill_valid), .kill_pid(kill_pid),
    .ret_valid(ret_valid), .ret_pid(ret_pid), .ret_pc(ret_pc), .ret_halt(ret_halt),
    .iss_valid(iss_valid), .iss_pid(iss_pid), .iss_pc(iss_pc),
    .iss_super(iss_super), .iss_task(iss_task), .full(full)
  );

  int nchk = 0;
  int nbad = 0;
  int cyc  = 0;
  bit done = 1'b0;
  bit dbl_seen = 1'b0;
  bit halt_all = 1'b0;
  int halt_pid = -1;
  int n_issue [N];

  // pipeline model: q[j] holds the issue seen j ticks ago
  logic           q_v  [DEP-1];
  logic [PW-1:0]  q_p  [DEP-1];
  logic [PCW-1:0] q_pc [DEP-1];

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (iss_valid) begin
      for (int j = 0; j < DEP - 1; j++)
        if (q_v[j] && q_p[j] == iss_pid) dbl_seen = 1'b1;
      n_issue[iss_pid]++;
    end
    for (int j = DEP - 2; j > 0; j--) begin
      q_v[j] = q_v[j-1]; q_p[j] = q_p[j-1]; q_pc[j] = q_pc[j-1];
    end
    q_v[0] = iss_valid; q_p[0] = iss_pid; q_pc[0] = iss_pc;
    ret_valid = q_v[DEP-2];
    ret_pid   = q_p[DEP-2];
    ret_pc    = q_pc[DEP-2] + 16'd1;
    ret_halt  = halt_all || (int'(q_p[DEP-2]) == halt_pid);
  endtask

  task automatic do_create(input bit sup, input bit newt, input int tid, input int pc,
                           output bit ack, output int pid, output int got_tid);
    cr_valid = 1'b1; cr_super = sup; cr_new_task = newt;
    cr_task = TW'(tid); cr_pc = PCW'(pc);
    tick();
    ack = cr_ack; pid = int'(cr_pid); got_tid = int'(cr_task_id);
    chk("R2", "ack/nak exclusive", int'(cr_ack & cr_nak), 0);
    cr_valid = 1'b0;
  endtask

  task automatic drain();
    halt_all = 1'b1;
    repeat (120) tick();
    halt_all = 1'b0;
    repeat (2) tick();
  endtask

  task automatic t_reset();
    chk("R1", "iss_valid after reset", int'(iss_valid), 0);
    chk("R1", "full after reset", int'(full), 0);
    chk("R1", "cr_ack after reset", int'(cr_ack), 0);
    chk("R1", "cr_nak after reset", int'(cr_nak), 0);
  endtask

  task automatic t_single();
    bit a; int p, t, gap_err, pc_err;
    do_create(1'b1, 1'b1, 0, 100, a, p, t);
    chk("R2", "single create ack", int'(a), 1);
    chk("R2", "single create pid", p, 0);
    chk("R8", "first supervisor task id", t, 0);
    tick();
    chk("R2", "first issue valid", int'(iss_valid), 1);
    chk("R2", "first issue pid", int'(iss_pid), 0);
    chk("R2", "first issue pc", int'(iss_pc), 100);
    chk("R2", "first issue class", int'(iss_super), 1);
    chk("R2", "first issue task", int'(iss_task), 0);
    gap_err = 0; pc_err = 0;
    for (int k = 1; k <= 32; k++) begin
      tick();
      if (iss_valid != ((k % 8) == 0)) gap_err++;
      if (iss_valid && int'(iss_pc) != 100 + k / 8) pc_err++;
    end
    chk("R12", "lone process issue spacing errors", gap_err, 0);
    chk("R5", "retired pc carried errors", pc_err, 0);
    drain();
    chk("R6", "halted lone process, bubble", int'(iss_valid), 0);
    gap_err = 0;
    for (int k = 0; k < 5; k++) begin
      tick();
      if (iss_valid) gap_err++;
    end
    chk("R7", "issues with no ready process", gap_err, 0);
  endtask

  task automatic t_rr8_kill();
    bit a; int p, t, err, prev, n3, n5, n0;
    for (int k = 0; k < 8; k++) begin
      do_create(1'b0, (k == 0), 0, 1000 * (k + 1), a, p, t);
      if (!a || p != k) err++;
    end
    chk("R2", "eight creates take pids 0..7", err, 0);
    tick();
    prev = int'(iss_pid);
    err = 0;
    for (int k = 0; k < 24; k++) begin
      tick();
      if (!iss_valid || int'(iss_pid) != (prev + 1) % 8) err++;
      prev = int'(iss_pid);
    end
    chk("R12", "eight processes, gaps or order errors", err, 0);
    chk("R3", "rotation wraps over eight ids", err, 0);
    // kill pid 3 while it is in flight
    for (int k = 0; k < 16 && !(iss_valid && iss_pid == 6'd3); k++) tick();
    kill_valid = 1'b1; kill_pid = 6'd3;
    tick();
    kill_valid = 1'b0;
    // kill pid 5 on the edge where it turns ready
    for (int k = 0; k < 16 && !(ret_valid && ret_pid == 6'd5 && !ret_halt); k++) tick();
    tick();
    kill_valid = 1'b1; kill_pid = 6'd5;
    tick();
    kill_valid = 1'b0;
    repeat (8) tick();
    n3 = n_issue[3]; n5 = n_issue[5]; n0 = n_issue[0];
    repeat (32) tick();
    chk("R11", "in-flight killed pid issues", n_issue[3] - n3, 0);
    chk("R11", "ready killed pid issues", n_issue[5] - n5, 0);
    chk("R11", "survivor keeps issuing", int'(n_issue[0] - n0 >= 3), 1);
    do_create(1'b0, 1'b0, 0, 7, a, p, t);
    chk("R11", "create reuses killed in-flight slot", p, 3);
    do_create(1'b0, 1'b0, 0, 9, a, p, t);
    chk("R11", "create reuses killed ready slot", p, 5);
    drain();
  endtask

  task automatic t_halt();
    bit a; int p, t, n1;
    for (int k = 0; k < 3; k++) do_create(1'b0, (k == 0), 0, 50, a, p, t);
    halt_pid = 1;
    repeat (12) tick();
    halt_pid = -1;
    n1 = n_issue[1];
    repeat (10) tick();
    chk("R6", "halted pid issues after halt", n_issue[1] - n1, 0);
    do_create(1'b0, 1'b0, 0, 60, a, p, t);
    chk("R6", "create reuses halted slot", p, 1);
    drain();
  endtask

  task automatic t_tasks();
    bit a; int p, t, err;
    err = 0;
    for (int k = 0; k < 7; k++) begin
      do_create(1'b0, 1'b1, 0, 200, a, p, t);
      if (!a || t != k) err++;
    end
    chk("R8", "seven user tasks get ids 0..6", err, 0);
    do_create(1'b0, 1'b1, 0, 200, a, p, t);
    chk("R9", "eighth user task refused", int'(a), 0);
    chk("R9", "eighth user task nak", int'(cr_nak), 1);
    do_create(1'b1, 1'b1, 0, 300, a, p, t);
    chk("R9", "supervisor task still granted", int'(a), 1);
    chk("R9", "supervisor task id", t, 0);
    do_create(1'b0, 1'b0, 3, 400, a, p, t);
    chk("R8", "join live user task", int'(a), 1);
    chk("R8", "joined task id", t, 3);
    do_create(1'b1, 1'b0, 5, 400, a, p, t);
    chk("R8", "join absent supervisor task", int'(a), 0);
    do_create(1'b0, 1'b0, 7, 400, a, p, t);
    chk("R8", "join out-of-range task id", int'(a), 0);
    drain();
    do_create(1'b0, 1'b1, 0, 500, a, p, t);
    chk("R8", "freed task id reused", t, 0);
    drain();
  endtask

  task automatic t_full();
    bit a; int p, t, err, prev;
    err = 0;
    for (int k = 0; k < N; k++) begin
      do_create(1'b0, (k == 0), 0, 10 * k, a, p, t);
      if (!a || p != k) err++;
    end
    chk("R10", "fifty creates accepted in slot order", err, 0);
    chk("R10", "full after fifty", int'(full), 1);
    do_create(1'b0, 1'b0, 0, 1, a, p, t);
    chk("R10", "create while full refused", int'(a), 0);
    repeat (100) tick();
    prev = int'(iss_pid);
    err = 0;
    for (int k = 0; k < 60; k++) begin
      tick();
      if (!iss_valid || int'(iss_pid) != (prev + 1) % N) err++;
      prev = int'(iss_pid);
    end
    chk("R3", "fifty-way rotation order errors", err, 0);
    drain();
    chk("R10", "full clears after drain", int'(full), 0);
  endtask

  initial begin
    for (int j = 0; j < N; j++) n_issue[j] = 0;
    for (int j = 0; j < DEP - 1; j++) begin
      q_v[j] = 1'b0; q_p[j] = '0; q_pc[j] = '0;
    end
    rst = 1'b1;
    cr_valid = 1'b0; cr_super = 1'b0; cr_new_task = 1'b0; cr_task = '0; cr_pc = '0;
    kill_valid = 1'b0; kill_pid = '0;
    ret_valid = 1'b0; ret_pid = '0; ret_pc = '0; ret_halt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "iss_valid during reset", int'(iss_valid), 0);
    rst = 1'b0;
    repeat (3) tick();
    t_reset();
    t_single();
    t_rr8_kill();
    t_halt();
    t_tasks();
    t_full();
    chk("R4", "process issued twice in one pipeline pass", int'(dbl_seen), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule